// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the sharer record for one line in a directory-based coherence scheme. It does not hold one presence bit for every node. Instead it stores up to `SLOTS` node identifiers, each `$clog2(NODES)` bits wide. Three commands drive it: a node gains a copy, a node drops its copy, and a node writes the line. On a write, the block returns the set of nodes whose copies must be invalidated. The entry then records the writer as the only sharer.

A sharer can arrive when every slot is already in use. The parameter `POLICY` then chooses what the entry does:
- **Broadcast (0):** the entry marks itself as "everyone may share", and the next write invalidates every other node.
- **Evict (1):** the oldest recorded sharer is displaced, and the block strobes that node's identifier out so that it can be invalidated.
- **Coarse (2):** the pointer storage is reused as a group vector, where one bit covers `GROUP` consecutive nodes. A write then invalidates whole groups.

The data path, memory access and message delivery belong to the surrounding directory controller.

Top module: `lpt_sharer_dir`

## Requirements
- R1: After a synchronous reset, the entry is in pointer mode (`entry_mode` = 0) with no sharers, and `inv_valid` and `victim_valid` are low.
- R2: In pointer mode, `cmd_op` = 0 (add) with a node not yet recorded adds it to `sharer_mask`, provided a slot is free. Adding a node that is already recorded changes nothing. In pointer mode the number of set bits in `sharer_mask` always equals the number of recorded sharers.
- R3: `cmd_op` = 1 (remove) in pointer mode drops the node and compacts the slots. The freed slot can then take a new sharer without overflow. Removing a node that is not recorded changes nothing.
- R4: `cmd_op` = 2 (write) raises `inv_valid` for exactly the cycle after the command. `inv_mask` then holds every recorded or implied sharer except the writer, and so covers every true sharer. After the write, `sharer_mask` holds only the writer and `entry_mode` is 0.
- R5: Under the broadcast policy, adding a new node to a full entry sets `entry_mode` to 1 and `sharer_mask` to all ones. A later write invalidates every node except the writer.
- R6: Under the evict policy, adding a new node to a full entry pulses `victim_valid` for one cycle. `victim_node` carries the oldest recorded sharer, which is removed. The new node is recorded and the entry stays in pointer mode.
- R7: Under the coarse policy, adding a new node to a full entry sets `entry_mode` to 2. Group bit g is set when any sharer, including the new one, lies in nodes g*GROUP to g*GROUP+GROUP-1. `sharer_mask` shows every node of each set group. Later adds set their group's bit.
- R8: Under the coarse policy, a write in mode 2 invalidates every node of every set group except the writer.
- R9: A remove while `entry_mode` is 1 or 2 has no effect on `sharer_mask`.
- R10: `cmd_op` = 3, and any cycle with `cmd_valid` low, leave the entry unchanged and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 add, 1 remove, 2 write, 3 no operation |
| cmd_node | input | $clog2(NODES) | Node the command refers to |
| sharer_mask | output | NODES | Nodes the entry currently treats as possible sharers |
| entry_mode | output | 2 | 0 pointer, 1 broadcast overflow, 2 group vector |
| inv_valid | output | 1 | One-cycle strobe: `inv_mask` is the invalidate set of a write |
| inv_mask | output | NODES | Nodes to invalidate for the last write |
| victim_valid | output | 1 | One-cycle strobe: a sharer was displaced (evict policy) |
| victim_node | output | $clog2(NODES) | Identifier of the displaced sharer |

## Verification
The assertions check, on every cycle, the rules that hold locally:
- in pointer mode the stored identifiers are distinct and match the slot count;
- a strobe appears only after the command that causes it;
- the writer is never in its own invalidate set;
- a write always leaves a single sharer in pointer mode.

Other behaviours depend on the history of commands, and only the bench scenarios show them. These are which sharer is the oldest when one is displaced, the group bits built at the moment of overflow, and the fact that a remove in an overflow mode leaves the set intact. The bench compares all three policies against a model with a full presence vector, using a fixed sequence and then random traffic.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_DEL   = 2'd1,
        OP_WRITE = 2'd2,
        OP_NOP   = 2'd3
    } lpt_op_e;

    typedef enum logic [1:0] {
        MODE_PTR   = 2'd0,
        MODE_ALL   = 2'd1,
        MODE_GROUP = 2'd2
    } lpt_mode_e;

    localparam int POL_BCAST  = 0;
    localparam int POL_EVICT  = 1;
    localparam int POL_COARSE = 2;

    // group index covering node n when each group spans k nodes
    function automatic int grp_of(input int n, input int k);
        return n / k;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/lpt_match.sv
module lpt_match #(
    parameter int SLOTS = 4,
    parameter int IDW   = 4,
    parameter int CW    = 3,
    parameter int IW    = 2
) (
    input  logic [SLOTS*IDW-1:0] store,
    input  logic [CW-1:0]        count,
    input  logic [IDW-1:0]       key,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);
    logic [SLOTS-1:0] hit_vec;

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign hit_vec[i] = (CW'(i) < count) && (store[i*IDW +: IDW] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/lpt_coarsen.sv
module lpt_coarsen
    import lpt_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDW   = 4,
    parameter int CW    = 3,
    parameter int GROUP = 4,
    parameter int CBITS = 4
) (
    input  logic [SLOTS*IDW-1:0] store,
    input  logic [CW-1:0]        count,
    input  logic [IDW-1:0]       new_node,
    output logic [CBITS-1:0]     group_bits
);
    always_comb begin
        group_bits = '0;
        for (int g = 0; g < CBITS; g++) begin
            if (grp_of(int'(new_node), GROUP) == g) group_bits[g] = 1'b1;
            for (int i = 0; i < SLOTS; i++) begin
                if ((CW'(i) < count) &&
                    (grp_of(int'(store[i*IDW +: IDW]), GROUP) == g))
                    group_bits[g] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpt_expand.sv
module lpt_expand
    import lpt_pkg::*;
#(
    parameter int NODES = 16,
    parameter int SLOTS = 4,
    parameter int IDW   = 4,
    parameter int CW    = 3,
    parameter int GROUP = 4
) (
    input  logic [SLOTS*IDW-1:0] store,
    input  logic [CW-1:0]        count,
    input  lpt_mode_e            mode,
    output logic [NODES-1:0]     mask
);
    localparam int STORE_W = SLOTS * IDW;

    always_comb begin
        mask = '0;
        unique case (mode)
            MODE_PTR: begin
                for (int i = 0; i < SLOTS; i++) begin
                    for (int n = 0; n < NODES; n++) begin
                        if ((CW'(i) < count) && (int'(store[i*IDW +: IDW]) == n))
                            mask[n] = 1'b1;
                    end
                end
            end
            MODE_ALL: mask = '1;
            MODE_GROUP: begin
                for (int n = 0; n < NODES; n++) begin
                    if (grp_of(n, GROUP) < STORE_W)
                        mask[n] = store[grp_of(n, GROUP)];
                end
            end
            default: mask = '1;
        endcase
    end
endmodule

// File: rtl/lpt_sharer_dir.sv
module lpt_sharer_dir
    import lpt_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int SLOTS  = 4,
    parameter int GROUP  = 4,
    parameter int POLICY = POL_BCAST
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [$clog2(NODES)-1:0]   cmd_node,
    output logic [NODES-1:0]           sharer_mask,
    output logic [1:0]                 entry_mode,
    output logic                       inv_valid,
    output logic [NODES-1:0]           inv_mask,
    output logic                       victim_valid,
    output logic [$clog2(NODES)-1:0]   victim_node
);
    localparam int IDW     = $clog2(NODES);
    localparam int STORE_W = SLOTS * IDW;
    localparam int CBITS   = ceil_div(NODES, GROUP);
    localparam int CW      = $clog2(SLOTS + 1);
    localparam int IW      = $clog2(SLOTS);

    if (POLICY == POL_COARSE && CBITS > STORE_W) begin : g_fit_err
        $error("group vector wider than pointer storage");
    end

    logic [STORE_W-1:0] store_q, store_n;
    logic [CW-1:0]      count_q, count_n;
    lpt_mode_e          mode_q, mode_n;
    logic               inv_valid_n, victim_valid_n;
    logic [NODES-1:0]   inv_mask_n;
    logic [IDW-1:0]     victim_node_n;

    logic               hit;
    logic [IW-1:0]      hit_idx;
    logic [CBITS-1:0]   group_bits;
    logic [NODES-1:0]   writer_bit;
    lpt_op_e            op;

    lpt_match #(.SLOTS(SLOTS), .IDW(IDW), .CW(CW), .IW(IW)) u_match (
        .store(store_q), .count(count_q), .key(cmd_node),
        .hit(hit), .hit_idx(hit_idx)
    );

    lpt_coarsen #(.SLOTS(SLOTS), .IDW(IDW), .CW(CW), .GROUP(GROUP), .CBITS(CBITS)) u_coarsen (
        .store(store_q), .count(count_q), .new_node(cmd_node), .group_bits(group_bits)
    );

    lpt_expand #(.NODES(NODES), .SLOTS(SLOTS), .IDW(IDW), .CW(CW), .GROUP(GROUP)) u_expand (
        .store(store_q), .count(count_q), .mode(mode_q), .mask(sharer_mask)
    );

    assign op         = lpt_op_e'(cmd_op);
    assign writer_bit = NODES'(1) << cmd_node;
    assign entry_mode = mode_q;

    always_comb begin
        store_n        = store_q;
        count_n        = count_q;
        mode_n         = mode_q;
        inv_valid_n    = 1'b0;
        inv_mask_n     = '0;
        victim_valid_n = 1'b0;
        victim_node_n  = victim_node;
        if (cmd_valid) begin
            unique case (op)
                OP_ADD: begin
                    if (mode_q == MODE_PTR && !hit) begin
                        if (count_q < CW'(SLOTS)) begin
                            for (int i = 0; i < SLOTS; i++) begin
                                if (CW'(i) == count_q) store_n[i*IDW +: IDW] = cmd_node;
                            end
                            count_n = count_q + CW'(1);
                        end else if (POLICY == POL_BCAST) begin
                            mode_n = MODE_ALL;
                        end else if (POLICY == POL_EVICT) begin
                            // slot 0 is always the oldest sharer
                            victim_valid_n = 1'b1;
                            victim_node_n  = store_q[IDW-1:0];
                            for (int i = 0; i < SLOTS - 1; i++)
                                store_n[i*IDW +: IDW] = store_q[(i+1)*IDW +: IDW];
                            store_n[(SLOTS-1)*IDW +: IDW] = cmd_node;
                        end else begin
                            store_n = '0;
                            store_n[CBITS-1:0] = group_bits;
                            count_n = '0;
                            mode_n  = MODE_GROUP;
                        end
                    end else if (mode_q == MODE_GROUP) begin
                        for (int g = 0; g < CBITS; g++) begin
                            if (grp_of(int'(cmd_node), GROUP) == g) store_n[g] = 1'b1;
                        end
                    end
                end
                OP_DEL: begin
                    if (mode_q == MODE_PTR && hit) begin
                        for (int i = 0; i < SLOTS - 1; i++) begin
                            if (IW'(i) >= hit_idx)
                                store_n[i*IDW +: IDW] = store_q[(i+1)*IDW +: IDW];
                        end
                        store_n[(SLOTS-1)*IDW +: IDW] = '0;
                        count_n = count_q - CW'(1);
                    end
                end
                OP_WRITE: begin
                    inv_valid_n = 1'b1;
                    inv_mask_n  = sharer_mask & ~writer_bit;
                    store_n     = '0;
                    store_n[IDW-1:0] = cmd_node;
                    count_n     = CW'(1);
                    mode_n      = MODE_PTR;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q      <= '0;
            count_q      <= '0;
            mode_q       <= MODE_PTR;
            inv_valid    <= 1'b0;
            inv_mask     <= '0;
            victim_valid <= 1'b0;
            victim_node  <= '0;
        end else begin
            store_q      <= store_n;
            count_q      <= count_n;
            mode_q       <= mode_n;
            inv_valid    <= inv_valid_n;
            inv_mask     <= inv_mask_n;
            victim_valid <= victim_valid_n;
            victim_node  <= victim_node_n;
        end
    end

    // R2: stored pointers are distinct and agree with the slot count
    assert_ptr_distinct_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PTR) |-> ($countones(sharer_mask) == int'(count_q)));

    // R4: invalidate strobe only follows a write command
    assert_inv_cause_R4: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> $past(cmd_valid && cmd_op == 2'd2));

    // R4: writer never in its own invalidate set
    assert_inv_no_writer_R4: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !inv_mask[$past(cmd_node)]);

    // R4: a write leaves exactly the writer, in pointer mode
    assert_write_single_R4: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_op == 2'd2) |-> (mode_q == MODE_PTR && count_q == CW'(1)));

    // R6: displacement only when a full entry took a new add
    assert_victim_cause_R6: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> ($past(count_q) == CW'(SLOTS) && $past(cmd_valid && cmd_op == 2'd0)));
endmodule

// File: tb/tb_lpt_sharer_dir.sv
`timescale 1ns/1ps
module tb_lpt_sharer_dir;
    localparam int NODES = 16;
    localparam int SLOTS = 4;
    localparam int GROUP = 4;
    localparam int IDW   = $clog2(NODES);
    localparam int NVEC  = 24;

    // {op[1:0], node[3:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        {2'd0,4'd1}, {2'd0,4'd2}, {2'd0,4'd3}, {2'd0,4'd2}, {2'd0,4'd4},
        {2'd0,4'd9}, {2'd1,4'd3}, {2'd0,4'd10}, {2'd2,4'd6}, {2'd0,4'd7},
        {2'd1,4'd7}, {2'd0,4'd7}, {2'd0,4'd8}, {2'd0,4'd12}, {2'd0,4'd13},
        {2'd3,4'd0}, {2'd1,4'd8}, {2'd0,4'd15}, {2'd2,4'd12}, {2'd0,4'd0},
        {2'd1,4'd5}, {2'd0,4'd1}, {2'd2,4'd0}, {2'd3,4'd9}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd3;
    logic [IDW-1:0] cmd_node = '0;

    logic [NODES-1:0] sm [3];
    logic [1:0]       md [3];
    logic             iv [3];
    logic [NODES-1:0] im [3];
    logic             vv [3];
    logic [IDW-1:0]   vn [3];

    always #2.5 clk = ~clk;

    lpt_sharer_dir #(.NODES(NODES), .SLOTS(SLOTS), .GROUP(GROUP), .POLICY(0)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node),
        .sharer_mask(sm[0]), .entry_mode(md[0]), .inv_valid(iv[0]), .inv_mask(im[0]),
        .victim_valid(vv[0]), .victim_node(vn[0]));
    lpt_sharer_dir #(.NODES(NODES), .SLOTS(SLOTS), .GROUP(GROUP), .POLICY(1)) dut_evict (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node),
        .sharer_mask(sm[1]), .entry_mode(md[1]), .inv_valid(iv[1]), .inv_mask(im[1]),
        .victim_valid(vv[1]), .victim_node(vn[1]));
    lpt_sharer_dir #(.NODES(NODES), .SLOTS(SLOTS), .GROUP(GROUP), .POLICY(2)) dut_coarse (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node),
        .sharer_mask(sm[2]), .entry_mode(md[2]), .inv_valid(iv[2]), .inv_mask(im[2]),
        .victim_valid(vv[2]), .victim_node(vn[2]));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model, one per policy, with an exact presence vector alongside
    int              mq  [3][SLOTS];
    int              mc  [3];
    int              mm  [3];
    bit [NODES-1:0]  mg  [3];
    bit [NODES-1:0]  ex  [3];
    bit [NODES-1:0]  exw [3];
    bit              eiv [3];
    bit [NODES-1:0]  eim [3];
    bit              evv [3];
    int              evn [3];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [NODES-1:0] mmask(input int p);
        bit [NODES-1:0] m = '0;
        if (mm[p] == 0) begin
            for (int i = 0; i < mc[p]; i++) m[mq[p][i]] = 1'b1;
        end else if (mm[p] == 1) begin
            m = '1;
        end else begin
            for (int n = 0; n < NODES; n++) m[n] = mg[p][n / GROUP];
        end
        return m;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 3; p++) begin
            mc[p] = 0; mm[p] = 0; mg[p] = '0; ex[p] = '0;
            eiv[p] = 0; evv[p] = 0; eim[p] = '0;
            for (int i = 0; i < SLOTS; i++) mq[p][i] = 0;
        end
    endtask

    task automatic model_step(input int op, input int node);
        for (int p = 0; p < 3; p++) begin
            int pos = -1;
            eiv[p] = 0; evv[p] = 0;
            for (int i = 0; i < mc[p]; i++) if (mq[p][i] == node) pos = i;
            case (op)
                0: begin
                    ex[p][node] = 1'b1;
                    if (mm[p] == 0 && pos < 0) begin
                        if (mc[p] < SLOTS) begin
                            mq[p][mc[p]] = node; mc[p]++;
                        end else if (p == 0) begin
                            mm[p] = 1;
                        end else if (p == 1) begin
                            evv[p] = 1; evn[p] = mq[p][0];
                            ex[p][mq[p][0]] = 1'b0;
                            for (int i = 0; i < SLOTS - 1; i++) mq[p][i] = mq[p][i+1];
                            mq[p][SLOTS-1] = node;
                        end else begin
                            mg[p] = '0;
                            for (int i = 0; i < SLOTS; i++) mg[p][mq[p][i] / GROUP] = 1'b1;
                            mg[p][node / GROUP] = 1'b1;
                            mm[p] = 2; mc[p] = 0;
                        end
                    end else if (mm[p] == 2) begin
                        mg[p][node / GROUP] = 1'b1;
                    end
                end
                1: begin
                    ex[p][node] = 1'b0;
                    if (mm[p] == 0 && pos >= 0) begin
                        for (int i = pos; i < SLOTS - 1; i++) mq[p][i] = mq[p][i+1];
                        mc[p]--;
                    end
                end
                2: begin
                    eiv[p] = 1;
                    eim[p] = mmask(p) & ~(NODES'(1) << node);
                    exw[p] = ex[p] & ~(NODES'(1) << node);
                    ex[p] = NODES'(1) << node;
                    mq[p][0] = node; mc[p] = 1; mm[p] = 0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic check_all();
        string tm [3] = '{"R2", "R6", "R7"};
        string tmd[3] = '{"R5", "R6", "R7"};
        string ti [3] = '{"R4", "R6", "R8"};
        for (int p = 0; p < 3; p++) begin
            chk(sm[p] == mmask(p), tm[p], sm[p], mmask(p));
            chk(md[p] == 2'(mm[p]), tmd[p], md[p], mm[p]);
            chk(iv[p] == eiv[p], ti[p], iv[p], eiv[p]);
            if (eiv[p]) begin
                chk(im[p] == eim[p], ti[p], im[p], eim[p]);
                // every true sharer other than the writer is covered (R4)
                chk((exw[p] & ~im[p]) == '0, "R4", im[p], exw[p]);
            end
            chk(vv[p] == evv[p], "R6", vv[p], evv[p]);
            if (evv[p]) chk(vn[p] == IDW'(evn[p]), "R6", vn[p], evn[p]);
        end
    endtask

    // drive at a falling edge, let the rising edge take it, check at the next falling edge
    task automatic apply(input int op, input int node);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_node  = IDW'(node);
        model_step(op, node);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        for (int p = 0; p < 3; p++) begin
            chk(sm[p] == '0, "R1", sm[p], 0);
            chk(md[p] == 2'd0, "R1", md[p], 0);
            chk(iv[p] == 1'b0 && vv[p] == 1'b0, "R1", {iv[p], vv[p]}, 0);
        end

        for (int k = 0; k < NVEC; k++) apply(int'(VEC[k][5:4]), int'(VEC[k][3:0]));

        // directed corner cases
        do_reset();
        apply(0, 1); apply(0, 2); apply(0, 3); apply(0, 4);
        apply(1, 2);
        apply(0, 5);
        chk(md[0] == 2'd0 && sm[0] == 16'h003A, "R3", sm[0], 16'h003A);
        chk(vv[1] == 1'b0, "R3", vv[1], 0);
        apply(1, 9);
        chk(sm[0] == 16'h003A, "R3", sm[0], 16'h003A);
        apply(0, 5);
        chk(sm[0] == 16'h003A && md[0] == 2'd0, "R2", sm[0], 16'h003A);
        apply(0, 6);
        chk(md[0] == 2'd1 && sm[0] == 16'hFFFF, "R5", sm[0], 16'hFFFF);
        chk(vv[1] == 1'b1 && vn[1] == 4'd1, "R6", vn[1], 1);
        chk(sm[1] == 16'h0078 && md[1] == 2'd0, "R6", sm[1], 16'h0078);
        chk(md[2] == 2'd2 && sm[2] == 16'h00FF, "R7", sm[2], 16'h00FF);
        @(negedge clk);
        chk(vv[1] == 1'b0 && iv[0] == 1'b0, "R10", vv[1], 0);
        chk(sm[0] == 16'hFFFF && sm[1] == 16'h0078 && sm[2] == 16'h00FF, "R10", sm[1], 16'h0078);
        apply(1, 4);
        chk(sm[0] == 16'hFFFF && md[0] == 2'd1, "R9", sm[0], 16'hFFFF);
        chk(sm[2] == 16'h00FF && md[2] == 2'd2, "R9", sm[2], 16'h00FF);
        apply(0, 13);
        chk(sm[2] == 16'hF0FF, "R7", sm[2], 16'hF0FF);
        apply(2, 3);
        chk(iv[0] == 1'b1 && im[0] == 16'hFFF7, "R5", im[0], 16'hFFF7);
        chk(im[2] == 16'hF0F7, "R8", im[2], 16'hF0F7);
        chk(im[1] == 16'h2060, "R4", im[1], 16'h2060);
        for (int p = 0; p < 3; p++)
            chk(sm[p] == 16'h0008 && md[p] == 2'd0, "R4", sm[p], 16'h0008);
        @(negedge clk);
        chk(iv[0] == 1'b0 && iv[2] == 1'b0, "R4", iv[0], 0);
        apply(3, 7);
        chk(sm[0] == 16'h0008 && iv[0] == 1'b0, "R10", sm[0], 16'h0008);

        // random traffic against the model
        do_reset();
        for (int k = 0; k < 1500; k++) begin
            int r  = int'($urandom_range(0, 9));
            int op = (r < 6) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3;
            apply(op, int'($urandom_range(0, NODES - 1)));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule